// File: doc/BRIEF.md
# Ethernet Destination Address Filter

This block decides, once per received frame, whether the frame is addressed to this station. The six destination address bytes arrive one per qualified cycle, the first of them flagged as the frame start. While the bytes stream in, the block runs a CRC-32 over them and keeps a copy of the address. When the sixth byte arrives it combines four tests into one registered accept or reject verdict: exact match against a programmed station address, broadcast, a 64-bucket multicast hash lookup, and a promiscuous override.

Configuration is written through a simple word-wide write port. Six byte registers hold the station address, two 32-bit words hold the 64-bit multicast hash table, and one control word holds three mode bits. The verdict stays on the outputs until the next frame start, so a downstream MAC stage can sample it at any point during the rest of the frame.

Top module: `eth_rx_addr_filter`

## Requirements
- R1: After a synchronous reset, `dec_valid` and `accept` are 0, and the station address, hash table and control bits are all zero. A frame to 00:00:00:00:00:00 is then accepted, and a broadcast frame is rejected.
- R2: `dec_valid` rises in the cycle after the sixth address byte is sampled. It clears in the cycle after a byte is sampled with `frm_start`, and otherwise holds with `accept` unchanged. `accept` is 0 whenever `dec_valid` is 0.
- R3: The hash index is bits [31:26] of a CRC-32 over the six bytes in arrival order. The CRC uses polynomial 0x04C11DB7 and is preset to all ones at frame start. Each byte is fed least significant bit first into a register that shifts toward its MSB, and no final inversion is applied. Index bit 5 selects the hash word (0: offset 6, 1: offset 7), and index bits [4:0] select the bit within that word. A multicast frame is accepted when that bit is 1.
- R4: When control bit 2 (multicast enable) is 0, no multicast frame is accepted through the hash, even with every hash bit set.
- R5: Station address byte k is written at config offset k (k = 0..5, data bits [7:0]) and is compared with the k-th received byte. A unicast frame is accepted only when all six bytes match.
- R6: A frame to FF:FF:FF:FF:FF:FF is accepted exactly when control bit 1 (broadcast enable) is 1. The hash table plays no part in this decision.
- R7: When control bit 0 (promiscuous) is 1, every frame is accepted.
- R8: A byte counts only when `byte_valid` is 1. Bytes received after the sixth, or before any frame start, are ignored. A frame start in the middle of an address restarts collection from that byte.
- R9: The address is multicast when bit 0 of the first received byte is 1. Such an address is never accepted through an exact station match. Config writes to offsets above 8 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Config write strobe |
| cfg_addr | input | 4 | Config offset: 0-5 station bytes, 6-7 hash words, 8 control |
| cfg_wdata | input | 32 | Config write data |
| byte_valid | input | 1 | Address byte qualifier |
| frm_start | input | 1 | First address byte of a frame (qualified by byte_valid) |
| byte_data | input | 8 | Destination address byte |
| dec_valid | output | 1 | Verdict valid, held until the next frame start |
| accept | output | 1 | Frame accepted |

## Verification
The hardest state to reach from the ports is a hit on one particular hash bucket, because the bucket depends on a CRC of the address. The bench computes the bucket of a chosen group address with its own bit-serial CRC. It then programs only that bit and expects acceptance. Next it programs only the mirror bit in the other hash word and expects rejection. Finally it searches a range of group addresses for one that lands in the opposite word, which exercises both word selects.

// File: rtl/eaf_pkg.sv
package eaf_pkg;

  localparam logic [31:0] CRC_POLY = 32'h04C11DB7;

  typedef struct packed {
    logic mcast_en;
    logic bcast_en;
    logic promisc;
  } eaf_ctrl_t;

  // One byte through a MSB-shifting CRC-32, data bits taken LSB first.
  function automatic logic [31:0] crc_step(input logic [31:0] c, input logic [7:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if (r[31] ^ d[i]) r = {r[30:0], 1'b0} ^ CRC_POLY;
      else              r = {r[30:0], 1'b0};
    end
    return r;
  endfunction

endpackage

// File: rtl/eaf_cfg_regs.sv
module eaf_cfg_regs
  import eaf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_W     = 64,
  parameter int REG_W      = 32,
  parameter int CFG_AW     = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_we,
  input  logic [CFG_AW-1:0]       cfg_addr,
  input  logic [REG_W-1:0]        cfg_wdata,
  output logic [8*ADDR_BYTES-1:0] station,
  output logic [HASH_W-1:0]       hash_tbl,
  output eaf_ctrl_t               ctrl
);
  localparam int HASH_WORDS = HASH_W / REG_W;
  localparam int HASH_BASE  = ADDR_BYTES;
  localparam int CTRL_OFF   = ADDR_BYTES + HASH_WORDS;

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_sta
    always_ff @(posedge clk) begin
      if (rst) station[8*i +: 8] <= '0;
      else if (cfg_we && cfg_addr == CFG_AW'(i)) station[8*i +: 8] <= cfg_wdata[7:0];
    end
  end

  for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hash
    always_ff @(posedge clk) begin
      if (rst) hash_tbl[REG_W*w +: REG_W] <= '0;
      else if (cfg_we && cfg_addr == CFG_AW'(HASH_BASE + w)) hash_tbl[REG_W*w +: REG_W] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl <= '0;
    else if (cfg_we && cfg_addr == CFG_AW'(CTRL_OFF)) ctrl <= eaf_ctrl_t'(cfg_wdata[2:0]);
  end
endmodule

// File: rtl/eaf_addr_capture.sv
module eaf_addr_capture
  import eaf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_IDX_W = 6,
  localparam int CNT_W     = $clog2(ADDR_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    byte_valid,
  input  logic                    frm_start,
  input  logic [7:0]              byte_data,
  output logic                    start_seen,
  output logic                    last_byte,
  output logic [8*ADDR_BYTES-1:0] addr_now,
  output logic [HASH_IDX_W-1:0]   hash_idx,
  output logic [CNT_W-1:0]        cnt
);
  logic [CNT_W-1:0]        cnt_q;
  logic [31:0]             crc_q, crc_nxt;
  logic [8*ADDR_BYTES-1:0] addr_q;

  assign start_seen = byte_valid && frm_start;
  assign last_byte  = byte_valid && !frm_start && (cnt_q == CNT_W'(ADDR_BYTES - 1));
  assign crc_nxt    = crc_step(frm_start ? 32'hFFFF_FFFF : crc_q, byte_data);
  assign hash_idx   = crc_nxt[31 -: HASH_IDX_W];
  assign cnt        = cnt_q;

  // Idle state is cnt_q == ADDR_BYTES: stray bytes fall through.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= CNT_W'(ADDR_BYTES);
      crc_q <= 32'hFFFF_FFFF;
    end else if (start_seen) begin
      cnt_q <= CNT_W'(1);
      crc_q <= crc_nxt;
    end else if (byte_valid && cnt_q < CNT_W'(ADDR_BYTES)) begin
      cnt_q <= cnt_q + CNT_W'(1);
      crc_q <= crc_nxt;
    end
  end

  for (genvar i = 0; i < ADDR_BYTES; i++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) addr_q[8*i +: 8] <= '0;
      else if (byte_valid && ((frm_start && i == 0) ||
                              (!frm_start && cnt_q == CNT_W'(i))))
        addr_q[8*i +: 8] <= byte_data;
    end
    if (i == ADDR_BYTES - 1) begin : g_tail
      assign addr_now[8*i +: 8] = byte_data;
    end else begin : g_held
      assign addr_now[8*i +: 8] = addr_q[8*i +: 8];
    end
  end
endmodule

// File: rtl/eaf_decide.sv
module eaf_decide
  import eaf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_IDX_W = 6,
  localparam int HASH_W    = 1 << HASH_IDX_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start_seen,
  input  logic                    last_byte,
  input  logic [8*ADDR_BYTES-1:0] addr_now,
  input  logic [8*ADDR_BYTES-1:0] station,
  input  logic [HASH_W-1:0]       hash_tbl,
  input  logic [HASH_IDX_W-1:0]   hash_idx,
  input  eaf_ctrl_t               ctrl,
  output logic                    dec_valid,
  output logic                    accept
);
  logic is_bcast, is_group, hash_hit, exact, verdict;

  assign is_bcast = &addr_now;
  assign is_group = addr_now[0];
  assign hash_hit = hash_tbl[hash_idx];
  assign exact    = (addr_now == station);

  always_comb begin
    if (ctrl.promisc)  verdict = 1'b1;
    else if (is_bcast) verdict = ctrl.bcast_en;
    else if (is_group) verdict = ctrl.mcast_en && hash_hit;
    else               verdict = exact;
  end

  always_ff @(posedge clk) begin
    if (rst || start_seen) begin
      dec_valid <= 1'b0;
      accept    <= 1'b0;
    end else if (last_byte) begin
      dec_valid <= 1'b1;
      accept    <= verdict;
    end
  end
endmodule

// File: rtl/eth_rx_addr_filter.sv
module eth_rx_addr_filter
  import eaf_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int HASH_IDX_W = 6,
  parameter int REG_W      = 32,
  parameter int CFG_AW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              byte_valid,
  input  logic              frm_start,
  input  logic [7:0]        byte_data,
  output logic              dec_valid,
  output logic              accept
);
  localparam int HASH_W = 1 << HASH_IDX_W;
  localparam int CNT_W  = $clog2(ADDR_BYTES + 1);

  logic [8*ADDR_BYTES-1:0] station, addr_now;
  logic [HASH_W-1:0]       hash_tbl;
  logic [HASH_IDX_W-1:0]   hash_idx;
  logic [CNT_W-1:0]        byte_cnt;
  logic                    start_seen, last_byte;
  eaf_ctrl_t               ctrl_q;

  eaf_cfg_regs #(.ADDR_BYTES(ADDR_BYTES), .HASH_W(HASH_W), .REG_W(REG_W), .CFG_AW(CFG_AW)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .station(station), .hash_tbl(hash_tbl), .ctrl(ctrl_q)
  );

  eaf_addr_capture #(.ADDR_BYTES(ADDR_BYTES), .HASH_IDX_W(HASH_IDX_W)) u_cap (
    .clk(clk), .rst(rst), .byte_valid(byte_valid), .frm_start(frm_start), .byte_data(byte_data),
    .start_seen(start_seen), .last_byte(last_byte), .addr_now(addr_now),
    .hash_idx(hash_idx), .cnt(byte_cnt)
  );

  eaf_decide #(.ADDR_BYTES(ADDR_BYTES), .HASH_IDX_W(HASH_IDX_W)) u_dec (
    .clk(clk), .rst(rst), .start_seen(start_seen), .last_byte(last_byte),
    .addr_now(addr_now), .station(station), .hash_tbl(hash_tbl), .hash_idx(hash_idx),
    .ctrl(ctrl_q), .dec_valid(dec_valid), .accept(accept)
  );
endmodule

// File: rtl/eaf_checker.sv
module eaf_checker #(
  parameter int ADDR_BYTES = 6,
  parameter int CNT_W      = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             byte_valid,
  input logic             frm_start,
  input logic [CNT_W-1:0] cnt,
  input logic [2:0]       ctrl,
  input logic             dec_valid,
  input logic             accept
);
  p_decide_after_last_r2: assert property (@(posedge clk) disable iff (rst)
    byte_valid && !frm_start && cnt == CNT_W'(ADDR_BYTES - 1) |=> dec_valid);

  p_start_clears_r2: assert property (@(posedge clk) disable iff (rst)
    byte_valid && frm_start |=> !dec_valid);

  p_hold_verdict_r2: assert property (@(posedge clk) disable iff (rst)
    dec_valid && !(byte_valid && frm_start) |=> dec_valid && $stable(accept));

  p_accept_qualified_r2: assert property (@(posedge clk) disable iff (rst)
    !dec_valid |-> !accept);

  p_promisc_accepts_r7: assert property (@(posedge clk) disable iff (rst)
    byte_valid && !frm_start && cnt == CNT_W'(ADDR_BYTES - 1) && ctrl[0] |=> accept);

  p_idle_stays_r8: assert property (@(posedge clk) disable iff (rst)
    cnt == CNT_W'(ADDR_BYTES) && !(byte_valid && frm_start) |=> cnt == CNT_W'(ADDR_BYTES) && $stable(dec_valid));
endmodule

bind eth_rx_addr_filter eaf_checker #(.ADDR_BYTES(ADDR_BYTES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .byte_valid(byte_valid), .frm_start(frm_start),
  .cnt(byte_cnt), .ctrl(ctrl_q), .dec_valid(dec_valid), .accept(accept)
);

// File: tb/eth_rx_addr_filter_test.sv
module eth_rx_addr_filter_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        byte_valid = 1'b0;
  logic        frm_start = 1'b0;
  logic [7:0]  byte_data = '0;
  logic        dec_valid, accept;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit live = 0;

  always #2.5 clk = ~clk;

  eth_rx_addr_filter uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .byte_valid(byte_valid), .frm_start(frm_start), .byte_data(byte_data),
    .dec_valid(dec_valid), .accept(accept)
  );

  // ---------------- reference model ----------------
  logic [7:0]  m_q[$];
  bit          m_active = 0, m_valid = 0, m_acc = 0;
  logic [47:0] m_sta = '0;
  logic [63:0] m_hash = '0;
  logic [2:0]  m_ctrl = '0;

  function automatic logic [31:0] ref_crc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int k = 0; k < 48; k++) begin
      bit fb = c[31] ^ a[k];
      c = c << 1;
      if (fb) c = c ^ 32'h04C11DB7;
    end
    return c;
  endfunction

  function automatic bit ref_decide(input logic [47:0] a);
    int idx = int'(ref_crc(a) >> 26);
    if (m_ctrl[0]) return 1;
    if (a == 48'hFFFF_FFFF_FFFF) return m_ctrl[1];
    if (a[0]) return m_ctrl[2] && m_hash[idx];
    return a == m_sta;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_q.delete(); m_active = 0; m_valid = 0; m_acc = 0;
      m_sta = '0; m_hash = '0; m_ctrl = '0;
    end else begin
      if (byte_valid && frm_start) begin
        m_q.delete(); m_q.push_back(byte_data);
        m_active = 1; m_valid = 0; m_acc = 0;
      end else if (byte_valid && m_active && m_q.size() < 6) begin
        m_q.push_back(byte_data);
        if (m_q.size() == 6) begin
          logic [47:0] a;
          for (int k = 0; k < 6; k++) a[8*k +: 8] = m_q[k];
          m_valid = 1; m_acc = ref_decide(a);
        end
      end
      if (cfg_we) begin
        if (cfg_addr < 6) m_sta[8*cfg_addr +: 8] = cfg_wdata[7:0];
        else if (cfg_addr == 6) m_hash[31:0] = cfg_wdata;
        else if (cfg_addr == 7) m_hash[63:32] = cfg_wdata;
        else if (cfg_addr == 8) m_ctrl = cfg_wdata[2:0];
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model (R2 timing and holding)
  always @(negedge clk) if (live) begin
    check(dec_valid == m_valid, "R2 dec_valid vs model", dec_valid, m_valid);
    check(accept == m_acc, "R2 accept vs model", accept, m_acc);
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_addr = 4'(a); cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic set_sta(input logic [47:0] s);
    for (int k = 0; k < 6; k++) wr(k, {24'h0, s[8*k +: 8]});
  endtask

  // Sends six bytes (byte 0 = a[7:0]); returns at the negedge after the last.
  task automatic send(input logic [47:0] a, input bit gaps);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); byte_valid = 1; frm_start = (k == 0); byte_data = a[8*k +: 8];
      if (gaps && k < 5) begin
        @(negedge clk); byte_valid = 0; frm_start = 0; byte_data = 8'hA5;
      end
    end
    @(negedge clk); byte_valid = 0; frm_start = 0;
  endtask

  task automatic expect_dec(input bit exp, input string req);
    check(dec_valid == 1'b1, req, dec_valid, 1);
    check(accept == exp, req, accept, exp);
  endtask

  initial begin
    logic [47:0] mc1, mc2;
    int i1, i2;
    repeat (3) @(negedge clk);
    rst = 0; live = 1;
    // R1: reset values
    check(dec_valid == 0 && accept == 0, "R1 outputs after reset", {dec_valid, accept}, 0);
    send(48'h0, 0);
    expect_dec(1, "R1 zero station matches zero address");
    send(48'hFFFF_FFFF_FFFF, 0);
    expect_dec(0, "R1 broadcast rejected with control cleared");

    // R5: exact unicast match
    set_sta(48'h5544_3322_1102);
    send(48'h5544_3322_1102, 0);
    expect_dec(1, "R5 exact match accepted");
    send(48'h5444_3322_1102, 0);
    expect_dec(0, "R5 last byte differs rejected");
    send(48'h5544_3322_1103 ^ 48'h2, 0);
    expect_dec(0, "R5 first byte differs rejected");

    // R6: broadcast, hash plays no part
    wr(6, 32'hFFFF_FFFF); wr(7, 32'hFFFF_FFFF); wr(8, 32'h4);
    send(48'hFFFF_FFFF_FFFF, 0);
    expect_dec(0, "R6 broadcast rejected though hash full");
    wr(8, 32'h2);
    send(48'hFFFF_FFFF_FFFF, 0);
    expect_dec(1, "R6 broadcast accepted when enabled");

    // R4: multicast disabled, hash full
    send(48'h0100_005E_0001, 0);
    expect_dec(0, "R4 multicast rejected when disabled");

    // R3: specific bucket
    mc1 = 48'h0100_005E_0001;
    i1 = int'(ref_crc(mc1) >> 26);
    wr(8, 32'h4);
    wr(6, i1 < 32 ? (32'h1 << (i1 % 32)) : 32'h0);
    wr(7, i1 >= 32 ? (32'h1 << (i1 % 32)) : 32'h0);
    send(mc1, 0);
    expect_dec(1, "R3 hash bucket hit accepted");
    wr(6, i1 >= 32 ? (32'h1 << (i1 % 32)) : 32'h0);
    wr(7, i1 < 32 ? (32'h1 << (i1 % 32)) : 32'h0);
    send(mc1, 0);
    expect_dec(0, "R3 mirror bit in other word rejected");
    mc2 = mc1; i2 = i1;
    for (int k = 0; k < 64 && (i2 / 32) == (i1 / 32); k++) begin
      mc2 = {8'(k), 40'h00_005E_0001};
      i2 = int'(ref_crc(mc2) >> 26);
    end
    wr(6, i2 < 32 ? (32'h1 << (i2 % 32)) : 32'h0);
    wr(7, i2 >= 32 ? (32'h1 << (i2 % 32)) : 32'h0);
    send(mc2, 0);
    expect_dec(1, "R3 bucket in opposite word accepted");
    send(mc1, 0);
    expect_dec(0, "R3 unset bucket rejected");
    wr(8, 32'h0);
    send(mc2, 0);
    expect_dec(0, "R4 set bucket rejected when disabled");

    // R9: group address equal to station is not an exact match
    set_sta(48'h0000_0000_0033);
    send(48'h0000_0000_0033, 0);
    expect_dec(0, "R9 group address not accepted by station match");
    wr(12, 32'h7);
    send(48'h0000_0000_0032, 0);
    expect_dec(0, "R9 write to unmapped offset ignored");

    // R7: promiscuous
    wr(8, 32'h1);
    send(48'h1234_5678_9A02, 0);
    expect_dec(1, "R7 promiscuous accepts foreign unicast");
    wr(8, 32'h0);

    // R8: gaps, trailing bytes, restart
    set_sta(48'hEEDD_CCBB_AA00);
    send(48'hEEDD_CCBB_AA00, 1);
    expect_dec(1, "R8 gapped bytes accepted");
    @(negedge clk); byte_valid = 1; byte_data = 8'h77;
    @(negedge clk); byte_data = 8'h01;
    @(negedge clk); byte_valid = 0;
    expect_dec(1, "R8 bytes after sixth ignored");
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); byte_valid = 1; frm_start = (k == 0); byte_data = 8'h10 + 8'(k);
    end
    send(48'hEEDD_CCBB_AA00, 0);
    expect_dec(1, "R8 restart mid address");

    // R2: exact timing
    for (int k = 0; k < 6; k++) begin
      @(negedge clk); byte_valid = 1; frm_start = (k == 0); byte_data = 8'h11;
      if (k == 1) check(dec_valid == 0, "R2 cleared after start", dec_valid, 0);
    end
    check(dec_valid == 0, "R2 not valid while sixth byte presented", dec_valid, 0);
    @(negedge clk); byte_valid = 0; frm_start = 0;
    expect_dec(0, "R2 valid one cycle after sixth byte");
    repeat (10) @(negedge clk);
    expect_dec(0, "R2 verdict held while idle");

    live = 0;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule